// File: doc/BRIEF.md
# Dual-Width Timer/Counter with Two Compare Channels

This block is a timer/counter that runs either as an 8-bit counter or as a 16-bit counter. A width-mode bit in a control register selects between the two. A 3-bit clock-select field sets the count source. The source can be a stopped state, the system clock divided by 1, 8, 64, 256 or 1024 through an internal prescaler chain, or an external input pin. The pin can be counted on its rising edges or on its falling edges. The pin is synchronized inside the block. Counting uses the pad input whatever direction the pin has elsewhere, so software can step the counter by toggling a pin it drives itself.

On every count tick, the counter value held before that tick is compared with two compare registers, A and B. Equality sets a sticky flag for that channel. The flags appear on two output ports and are cleared by writing ones to the flag register. A CPU write to the counter low byte suppresses compare detection on the tick that follows, so that loading the counter with the compare value does not produce a match at once. All state is reached through a byte-wide register interface with registered read data.

Top module: `dual_width_timer`

## Requirements
- R1: After synchronous reset, every register reads 0x00 and both flag outputs are low.
- R2: The register map is as follows. Address 0 is control: bits 2:0 hold the clock select and bit 3 holds the width mode, with 1 meaning 16-bit. Addresses 1 and 2 are the counter low and high bytes. Addresses 3 and 4 are compare A low and high. Addresses 5 and 6 are compare B low and high. Address 7 holds the flags, with bit 0 for A and bit 1 for B. Each written byte reads back on the cycle after its address is presented.
- R3: Clock-select code 0 stops the counter. Codes 1 to 5 advance it once per system clock, or once every 8, 64, 256 or 1024 clocks respectively.
- R4: Code 7 counts each rising edge of the external pin exactly once, and code 6 counts each falling edge exactly once. Edges of the other polarity are ignored.
- R5: In 8-bit mode the low byte wraps from 0xFF to 0x00 and the high byte is left unchanged.
- R6: In 16-bit mode a low-byte carry increments the high byte, and the counter wraps from 0xFFFF to 0x0000.
- R7: On each tick, a counter value before the tick that equals a compare register sets that channel's flag. In 8-bit mode only the low bytes are compared.
- R8: In 16-bit mode all 16 bits of the counter and the compare register must match.
- R9: A write to the counter low byte suppresses compare detection on the next tick. A cycle that writes either counter byte neither counts nor compares.
- R10: Flags are sticky. Writing 1 to a flag bit clears that flag, and writing 0 to it has no effect.
- R11: Output ports cmp_a_flag and cmp_b_flag follow flag bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_pin | input | 1 | External count pin (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| cmp_a_flag | output | 1 | Sticky compare-A match flag |
| cmp_b_flag | output | 1 | Sticky compare-B match flag |

## Verification
Read data is due one clock after the address is presented. A counter change lands on the same edge as its tick, and a flag rises on the edge of the matching tick. An external pin change is counted on the third rising clock edge after it, because of the two synchronizer stages and the edge register. The bench drives inputs and samples outputs on falling edges. It bounds every counting run with two control writes, so the number of ticks in a run equals the number of edges between those writes. Each counter read is queued with its expected byte and compared one cycle later.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_CMP   = 2;
  localparam int ADDR_W    = 3;
  localparam int NUM_TAPS  = 4;
  localparam int SYNC_N    = 2;
  // prescaler tap widths: divide by 8, 64, 256, 1024
  localparam int TAP_SHIFT [NUM_TAPS] = '{3, 6, 8, 10};

  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  localparam logic [ADDR_W-1:0] A_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS    = 3'd7;

  function automatic logic [ADDR_W-1:0] cmp_addr(input int ch, input logic hi);
    return ADDR_W'(int'(A_CMP_BASE) + 2 * ch + int'(hi));
  endfunction
endpackage

// File: rtl/dwt_prescaler.sv
module dwt_prescaler
  import dwt_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  output logic [NUM_TAPS-1:0] tap
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // one-cycle pulse each time the low bits of the divider roll over
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap[g] = &pre_q[TAP_SHIFT[g]-1:0];
  end
endmodule

// File: rtl/dwt_edge_detect.sv
module dwt_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise_p,
  output logic fall_p
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_p =  sync_q[STAGES-1] && !prev_q;
  assign fall_p = !sync_q[STAGES-1] &&  prev_q;
endmodule

// File: rtl/dwt_counter.sv
module dwt_counter #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                wide,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [2*BYTE_W-1:0] cnt,
  output logic                cmp_en
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              blk_q;
  logic              step;

  // a cycle that writes the counter neither counts nor compares
  assign step = tick && !wr_lo && !wr_hi;

  always_ff @(posedge clk) begin
    if (rst)        lo_q <= '0;
    else if (wr_lo) lo_q <= wdata;
    else if (step)  lo_q <= lo_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                               hi_q <= '0;
    else if (wr_hi)                        hi_q <= wdata;
    else if (step && wide && (&lo_q))      hi_q <= hi_q + 1'b1;
  end

  // low-byte write arms a one-tick compare blanking
  always_ff @(posedge clk) begin
    if (rst)        blk_q <= 1'b0;
    else if (wr_lo) blk_q <= 1'b1;
    else if (tick)  blk_q <= 1'b0;
  end

  assign cnt    = {hi_q, lo_q};
  assign cmp_en = step && !blk_q;
endmodule

// File: rtl/dwt_compare.sv
module dwt_compare #(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] cnt,
  input  logic [2*BYTE_W-1:0] ref_val,
  input  logic                wide,
  output logic                hit
);
  assign hit = wide ? (cnt == ref_val)
                    : (cnt[BYTE_W-1:0] == ref_val[BYTE_W-1:0]);
endmodule

// File: rtl/dual_width_timer.sv
module dual_width_timer
  import dwt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk_pin,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              cmp_a_flag,
  output logic              cmp_b_flag
);
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int CTRL_W = 4;
  localparam int PRE_W  = TAP_SHIFT[NUM_TAPS-1];

  logic [CTRL_W-1:0]            ctrl_q;
  clk_sel_e                     clk_sel;
  logic                         wide;
  logic [NUM_TAPS-1:0]          tap;
  logic                         ext_rise, ext_fall;
  logic                         tick;
  logic [CNT_W-1:0]             cnt_q;
  logic                         cmp_en;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [NUM_CMP-1:0]           hit;
  logic [NUM_CMP-1:0]           flag_q;
  logic [BYTE_W-1:0]            rd_mux;
  logic [BYTE_W-1:0]            rdata_q;
  logic                         wr_ctrl, wr_lo, wr_hi, wr_flags;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_lo    = reg_wr && (reg_addr == A_CNT_LO);
  assign wr_hi    = reg_wr && (reg_addr == A_CNT_HI);
  assign wr_flags = reg_wr && (reg_addr == A_FLAGS);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  assign clk_sel = clk_sel_e'(ctrl_q[2:0]);
  assign wide    = ctrl_q[3];

  dwt_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk (clk),
    .rst (rst),
    .tap (tap)
  );

  dwt_edge_detect #(.STAGES(SYNC_N)) i_edge (
    .clk    (clk),
    .rst    (rst),
    .pin    (ext_clk_pin),
    .rise_p (ext_rise),
    .fall_p (ext_fall)
  );

  always_comb begin
    unique case (clk_sel)
      CS_STOP:     tick = 1'b0;
      CS_DIV1:     tick = 1'b1;
      CS_DIV8:     tick = tap[0];
      CS_DIV64:    tick = tap[1];
      CS_DIV256:   tick = tap[2];
      CS_DIV1024:  tick = tap[3];
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = 1'b0;
    endcase
  end

  dwt_counter #(.BYTE_W(BYTE_W)) i_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .wide   (wide),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wdata  (reg_wdata),
    .cnt    (cnt_q),
    .cmp_en (cmp_en)
  );

  for (genvar ch = 0; ch < NUM_CMP; ch++) begin : g_ch
    logic [CNT_W-1:0] cmp_r;
    logic             flag_r;
    logic             sel_lo, sel_hi, clr;

    assign sel_lo = reg_wr && (reg_addr == cmp_addr(ch, 1'b0));
    assign sel_hi = reg_wr && (reg_addr == cmp_addr(ch, 1'b1));
    assign clr    = wr_flags && reg_wdata[ch];

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_r <= '0;
      end else begin
        if (sel_lo) cmp_r[BYTE_W-1:0]     <= reg_wdata;
        if (sel_hi) cmp_r[CNT_W-1:BYTE_W] <= reg_wdata;
      end
    end

    dwt_compare #(.BYTE_W(BYTE_W)) i_cmp (
      .cnt     (cnt_q),
      .ref_val (cmp_r),
      .wide    (wide),
      .hit     (hit[ch])
    );

    // a match in the same cycle as a clear keeps the flag set
    always_ff @(posedge clk) begin
      if (rst)                   flag_r <= 1'b0;
      else if (cmp_en && hit[ch]) flag_r <= 1'b1;
      else if (clr)              flag_r <= 1'b0;
    end

    assign cmp_q[ch]  = cmp_r;
    assign flag_q[ch] = flag_r;
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_CTRL)   rd_mux[CTRL_W-1:0]  = ctrl_q;
    if (reg_addr == A_CNT_LO) rd_mux              = cnt_q[BYTE_W-1:0];
    if (reg_addr == A_CNT_HI) rd_mux              = cnt_q[CNT_W-1:BYTE_W];
    if (reg_addr == A_FLAGS)  rd_mux[NUM_CMP-1:0] = flag_q;
    for (int c = 0; c < NUM_CMP; c++) begin
      if (reg_addr == cmp_addr(c, 1'b0)) rd_mux = cmp_q[c][BYTE_W-1:0];
      if (reg_addr == cmp_addr(c, 1'b1)) rd_mux = cmp_q[c][CNT_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign reg_rdata  = rdata_q;
  assign cmp_a_flag = flag_q[0];
  assign cmp_b_flag = flag_q[1];
endmodule

// File: rtl/dwt_checker.sv
module dwt_checker
  import dwt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wdata0,
  input logic [2:0]        clk_sel,
  input logic              wide,
  input logic              tick,
  input logic              rise,
  input logic              fall,
  input logic [15:0]       cnt,
  input logic              flag_a
);
  logic cnt_wr, clr_a, pend_q;

  assign cnt_wr = reg_wr && (reg_addr == A_CNT_LO || reg_addr == A_CNT_HI);
  assign clr_a  = reg_wr && (reg_addr == A_FLAGS) && wdata0;

  // independent record of a pending blanked tick
  always_ff @(posedge clk) begin
    if (rst)                                  pend_q <= 1'b0;
    else if (reg_wr && reg_addr == A_CNT_LO)  pend_q <= 1'b1;
    else if (tick)                            pend_q <= 1'b0;
  end

  p_stop_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 3'd0) |-> !tick);

  p_edge_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise, fall}));

  p_edge_single_r4: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

  p_step8_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !wide && !cnt_wr) |=>
      (cnt[7:0] == $past(cnt[7:0]) + 8'd1) && (cnt[15:8] == $past(cnt[15:8])));

  p_step16_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && wide && !cnt_wr) |=> (cnt == $past(cnt) + 16'd1));

  p_blank_r9: assert property (@(posedge clk) disable iff (rst)
    (pend_q && tick && !flag_a) |=> !flag_a);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_a && !clr_a) |=> flag_a);

  p_stopped_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 3'd0 && !cnt_wr) |=> $stable(cnt));
endmodule

bind dual_width_timer dwt_checker i_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .wdata0   (reg_wdata[0]),
  .clk_sel  (ctrl_q[2:0]),
  .wide     (ctrl_q[3]),
  .tick     (tick),
  .rise     (ext_rise),
  .fall     (ext_fall),
  .cnt      (cnt_q),
  .flag_a   (cmp_a_flag)
);

// File: tb/test_dual_width_timer.sv
module test_dual_width_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] rdata;
  logic       fa, fb;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  logic rd_req = 1'b0;
  logic rd_req_q = 1'b0;

  localparam logic [2:0] R_CTRL = 3'd0, R_LO = 3'd1, R_HI = 3'd2,
                         R_AL = 3'd3, R_AH = 3'd4, R_BL = 3'd5, R_BH = 3'd6,
                         R_FLG = 3'd7;

  always #10 clk = ~clk;

  dual_width_timer i_dual_width_timer (
    .clk         (clk),
    .rst         (rst),
    .ext_clk_pin (pin),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (rdata),
    .cmp_a_flag  (fa),
    .cmp_b_flag  (fb)
  );

  always @(posedge clk) rd_req_q <= rd_req;

  // monitor: pops one expected byte per completed read
  always @(negedge clk) begin
    item_t it;
    if (rd_req_q) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R2: read data %h with no expected item, expected none", rdata);
      end else begin
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: read %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    reg_addr = a;
    rd_req   = 1'b1;
    @(negedge clk);
    rd_req   = 1'b0;
  endtask

  task automatic chk_flags(input logic ea, input logic eb, input string tag);
    checks++;
    if (fa !== ea || fb !== eb) begin
      fails++;
      $display("FAIL %s: flags a=%b b=%b expected a=%b b=%b", tag, fa, fb, ea, eb);
    end
  endtask

  // ticks occur on exactly len edges between the two control writes
  task automatic run(input logic [7:0] code, input int len);
    wr(R_CTRL, code);
    repeat (len - 1) @(negedge clk);
    wr(R_CTRL, code & 8'h08);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1;
      repeat (5) @(negedge clk);
      pin = 1'b0;
      repeat (5) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1: watchdog expired at 200000 cycles, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_flags(1'b0, 1'b0, "R1 reset flags");
    for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 reset register");

    // R2 register readback
    wr(R_AL, 8'h07); wr(R_AH, 8'h34); wr(R_BL, 8'hA5); wr(R_BH, 8'h5A);
    wr(R_CTRL, 8'h08);
    rd(R_AL, 8'h07, "R2 cmpA lo"); rd(R_AH, 8'h34, "R2 cmpA hi");
    rd(R_BL, 8'hA5, "R2 cmpB lo"); rd(R_BH, 8'h5A, "R2 cmpB hi");
    rd(R_CTRL, 8'h08, "R2 ctrl");
    wr(R_CTRL, 8'h00);
    rd(R_CTRL, 8'h00, "R2 ctrl clear");
    wr(R_BL, 8'h00); wr(R_BH, 8'h00);

    // R7 8-bit compare A, high bytes differ (0x12 vs 0x34)
    wr(R_HI, 8'h12); wr(R_LO, 8'h05);
    run(8'h01, 2);
    chk_flags(1'b0, 1'b0, "R7 no match before 0x07");
    rd(R_LO, 8'h07, "R3 div1 count");
    run(8'h01, 1);
    chk_flags(1'b1, 1'b0, "R7 match on low byte");
    rd(R_FLG, 8'h01, "R11 flag register");
    rd(R_LO, 8'h08, "R3 count after match");

    // R10 write-one-to-clear
    wr(R_FLG, 8'h00);
    chk_flags(1'b1, 1'b0, "R10 write zero ignored");
    wr(R_FLG, 8'h01);
    chk_flags(1'b0, 1'b0, "R10 write one clears");

    // R9 blanking after low-byte write
    wr(R_LO, 8'h07);
    run(8'h01, 1);
    chk_flags(1'b0, 1'b0, "R9 blanked tick");
    rd(R_LO, 8'h08, "R9 count still advanced");
    wr(R_LO, 8'h06);
    run(8'h01, 3);
    chk_flags(1'b1, 1'b0, "R9 second tick compares");
    rd(R_LO, 8'h09, "R9 count");
    wr(R_FLG, 8'h01);

    // R9 write while running
    wr(R_CTRL, 8'h01);
    wr(R_LO, 8'h07);
    repeat (2) @(negedge clk);
    wr(R_CTRL, 8'h00);
    chk_flags(1'b0, 1'b0, "R9 running write blanked");
    rd(R_LO, 8'h0A, "R9 write cycle does not count");

    // R5 8-bit wrap, R7 channel B matches low byte 0x00
    wr(R_HI, 8'h12); wr(R_LO, 8'hFE);
    run(8'h01, 3);
    chk_flags(1'b0, 1'b1, "R7 channel B at 0x00");
    rd(R_LO, 8'h01, "R5 low wrap");
    rd(R_HI, 8'h12, "R5 high unchanged");
    wr(R_FLG, 8'h02);

    // R8 16-bit compare on channel B
    wr(R_BL, 8'h02); wr(R_BH, 8'h01);
    wr(R_HI, 8'h00); wr(R_LO, 8'hFE);
    run(8'h09, 4);
    chk_flags(1'b0, 1'b0, "R8 before 0x0102");
    rd(R_LO, 8'h02, "R6 carry lo");
    rd(R_HI, 8'h01, "R6 carry hi");
    run(8'h09, 1);
    chk_flags(1'b0, 1'b1, "R8 full match");
    wr(R_FLG, 8'h02);

    // R8 low byte alone does not match in 16-bit mode
    wr(R_HI, 8'h00); wr(R_LO, 8'h05);
    run(8'h09, 3);
    chk_flags(1'b0, 1'b0, "R8 high byte mismatch");
    rd(R_LO, 8'h08, "R8 count");

    // R6 16-bit wrap
    wr(R_HI, 8'hFF); wr(R_LO, 8'hFE);
    run(8'h09, 3);
    rd(R_LO, 8'h01, "R6 wrap lo");
    rd(R_HI, 8'h00, "R6 wrap hi");

    // R3 prescaler taps in 8-bit mode
    wr(R_HI, 8'h00); wr(R_LO, 8'h00);
    run(8'h02, 80);
    rd(R_LO, 8'd10, "R3 div8");
    run(8'h03, 640);
    rd(R_LO, 8'd20, "R3 div64");
    run(8'h04, 512);
    rd(R_LO, 8'd22, "R3 div256");
    run(8'h05, 2048);
    rd(R_LO, 8'd24, "R3 div1024");
    repeat (20) @(negedge clk);
    rd(R_LO, 8'd24, "R3 stopped holds");

    // R4 external pin, rising then falling
    wr(R_CTRL, 8'h07);
    pulses(3);
    wr(R_CTRL, 8'h00);
    rd(R_LO, 8'd27, "R4 rising edges");
    wr(R_CTRL, 8'h06);
    pulses(3);
    wr(R_CTRL, 8'h00);
    rd(R_LO, 8'd30, "R4 falling edges");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R2: %0d reads never completed, expected 0", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule